// File: doc/BRIEF.md
# Multi-Mode Baud Tick Generator

This block derives two timing strobes from a serial port's source clock. A sample strobe marks the end of each prescale group. A bit strobe marks the end of each serial bit period. Three division equations are available, selected by two mode bits:

- a fixed divide-by-16 prescale;
- a programmable prescale of (B+1);
- a direct divide with no prescale.

Each equation is followed by a (A+2) group count. A is a 16-bit base divisor and B is a 4-bit prescale divisor.

Configuration is taken in on a single-cycle write strobe. The write restarts both counters, so the new rate begins cleanly. Settings that break a mode's minimum-value rule raise an error flag. In that case the generator runs at the smallest legal value rather than stopping.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the block is in the ×16 mode with A = 0: `smp_tick` every 16 cycles, `bit_tick` every 32 cycles, `cfg_err` low, and no tick while reset is held.
- R2: With `cfg_mode_en` = 0, `smp_tick` has period 16 and `bit_tick` has period 16 × (A+2).
- R3: With `cfg_mode_en` = 1 and `cfg_div_one` = 0, `smp_tick` has period B+1 and `bit_tick` has period (B+1) × (A+2).
- R4: In the R3 mode a B below 8 sets `cfg_err` and the block runs as if B = 8.
- R5: With `cfg_mode_en` = 1 and `cfg_div_one` = 1, `smp_tick` fires every cycle and `bit_tick` has period A+2; B has no effect.
- R6: In the R5 mode an A below 3 sets `cfg_err` and the block runs as if A = 3.
- R7: `cfg_div_one` has no effect while `cfg_mode_en` = 0; the block behaves as in R2 and `cfg_err` stays low.
- R8: In a cycle with `cfg_wr` high neither tick fires. Both counters restart from the new setting. The first `smp_tick` comes in the G-th cycle after the write edge, where G is the prescale period. The first `bit_tick` comes in the G × (A+2)-th cycle.
- R9: `bit_tick` is only ever high in a cycle where `smp_tick` is high.
- R10: `cfg_err` is registered at the edge that takes a write and changes at no other time. A legal write clears it.
- R11: Changes on the divisor and mode inputs while `cfg_wr` is low have no effect on either tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_base_div | input | 16 | Base divisor A |
| cfg_pre_div | input | 4 | Prescale divisor B |
| cfg_mode_en | input | 1 | Selects the programmable modes |
| cfg_div_one | input | 1 | Direct divide, honoured only with `cfg_mode_en` |
| bit_tick | output | 1 | One-cycle strobe per bit period |
| smp_tick | output | 1 | One-cycle strobe per prescale group |
| cfg_err | output | 1 | The held setting breaks the active mode's minimum |

## Verification
The bench covers the corner cases of the divider chain:

- **Clamp boundaries (B = 7/8 and A = 2/3).** A missing clamp would show up as a short period or a stalled counter.
- **The ignored `cfg_div_one` bit.** Decoding it alone would wrongly select direct divide.
- **The prescale-by-one mode.** An off-by-one reload would drop every other sample tick.
- **The write cycle itself.** A design that let the old count finish would emit a partial-period tick or a late first tick.
- **Error-flag retention when inputs move without a write.** A combinational flag, or one that tracks live inputs, would toggle there.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    MODE_X16    = 2'd0,
    MODE_PRESC  = 2'd1,
    MODE_DIRECT = 2'd2
  } baud_mode_e;

  localparam int X16_GROUP  = 16;
  localparam int PRESC_BMIN = 8;
  localparam int DIRECT_AMIN = 3;
endpackage

// File: rtl/baud_cfg.sv
module baud_cfg
  import baud_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PRE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [DIV_W-1:0]   a_in,
  input  logic [PRE_W-1:0]   b_in,
  input  logic               en_in,
  input  logic               one_in,
  output logic [PRE_W-1:0]   nxt_pre_rld,
  output logic [DIV_W:0]     nxt_bit_rld,
  output baud_mode_e         mode_q,
  output logic               err_q
);
  localparam logic [PRE_W-1:0] X16_RLD  = PRE_W'(X16_GROUP - 1);
  localparam logic [PRE_W-1:0] BMIN     = PRE_W'(PRESC_BMIN);
  localparam logic [DIV_W-1:0] AMIN     = DIV_W'(DIRECT_AMIN);
  localparam logic [DIV_W:0]   RST_BRLD = (DIV_W+1)'(1);

  function automatic baud_mode_e decode_mode(logic en, logic one);
    if (!en)     return MODE_X16;
    else if (one) return MODE_DIRECT;
    else          return MODE_PRESC;
  endfunction

  // prescale reload: group length minus one
  function automatic logic [PRE_W-1:0] grp_rld(baud_mode_e m, logic [PRE_W-1:0] b);
    case (m)
      MODE_PRESC:  return (b < BMIN) ? BMIN : b;
      MODE_DIRECT: return '0;
      default:     return X16_RLD;
    endcase
  endfunction

  // group-count reload: A+1 (clamped A in direct mode)
  function automatic logic [DIV_W:0] base_rld(baud_mode_e m, logic [DIV_W-1:0] a);
    logic [DIV_W-1:0] a_eff;
    a_eff = (m == MODE_DIRECT && a < AMIN) ? AMIN : a;
    return {1'b0, a_eff} + (DIV_W+1)'(1);
  endfunction

  function automatic logic illegal(baud_mode_e m, logic [DIV_W-1:0] a, logic [PRE_W-1:0] b);
    return (m == MODE_PRESC && b < BMIN) || (m == MODE_DIRECT && a < AMIN);
  endfunction

  logic [PRE_W-1:0] pre_rld_q;
  logic [DIV_W:0]   bit_rld_q;
  baud_mode_e       wr_mode;

  assign wr_mode     = decode_mode(en_in, one_in);
  assign nxt_pre_rld = cfg_wr ? grp_rld(wr_mode, b_in)  : pre_rld_q;
  assign nxt_bit_rld = cfg_wr ? base_rld(wr_mode, a_in) : bit_rld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_rld_q <= X16_RLD;
      bit_rld_q <= RST_BRLD;
      mode_q    <= MODE_X16;
      err_q     <= 1'b0;
    end else if (cfg_wr) begin
      pre_rld_q <= nxt_pre_rld;
      bit_rld_q <= nxt_bit_rld;
      mode_q    <= wr_mode;
      err_q     <= illegal(wr_mode, a_in, b_in);
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PRE_W = 4,
  parameter logic [PRE_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [PRE_W-1:0] rld,
  output logic [PRE_W-1:0] pre_cnt,
  output logic             smp_evt
);
  assign smp_evt = (pre_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                    pre_cnt <= RST_VAL;
    else if (cfg_wr || smp_evt) pre_cnt <= rld;
    else                        pre_cnt <= pre_cnt - 1'b1;
  end
endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter #(
  parameter int DIV_W = 16,
  parameter logic [DIV_W:0] RST_VAL = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic           smp_evt,
  input  logic [DIV_W:0] rld,
  output logic [DIV_W:0] bit_cnt,
  output logic           bit_evt
);
  assign bit_evt = smp_evt && (bit_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          bit_cnt <= RST_VAL;
    else if (cfg_wr)  bit_cnt <= rld;
    else if (smp_evt) bit_cnt <= bit_evt ? rld : bit_cnt - 1'b1;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_base_div,
  input  logic [PRE_W-1:0] cfg_pre_div,
  input  logic             cfg_mode_en,
  input  logic             cfg_div_one,
  output logic             bit_tick,
  output logic             smp_tick,
  output logic             cfg_err
);
  localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(X16_GROUP - 1);
  localparam logic [DIV_W:0]   BIT_RST = (DIV_W+1)'(1);

  logic [PRE_W-1:0] nxt_pre_rld;
  logic [DIV_W:0]   nxt_bit_rld;
  baud_mode_e       mode_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W:0]   bit_cnt;
  logic             smp_evt;
  logic             bit_evt;

  baud_cfg #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
    .a_in(cfg_base_div), .b_in(cfg_pre_div),
    .en_in(cfg_mode_en), .one_in(cfg_div_one),
    .nxt_pre_rld(nxt_pre_rld), .nxt_bit_rld(nxt_bit_rld),
    .mode_q(mode_q), .err_q(cfg_err)
  );

  baud_prescaler #(.PRE_W(PRE_W), .RST_VAL(PRE_RST)) u_pre (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .rld(nxt_pre_rld),
    .pre_cnt(pre_cnt), .smp_evt(smp_evt)
  );

  baud_bit_counter #(.DIV_W(DIV_W), .RST_VAL(BIT_RST)) u_bit (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .smp_evt(smp_evt),
    .rld(nxt_bit_rld), .bit_cnt(bit_cnt), .bit_evt(bit_evt)
  );

  assign smp_tick = smp_evt && !cfg_wr;
  assign bit_tick = bit_evt && !cfg_wr;
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk
  import baud_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PRE_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic             cfg_mode_en,
  input logic             smp_tick,
  input logic             bit_tick,
  input logic             cfg_err,
  input baud_mode_e       mode_q,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PRE_W-1:0] nxt_pre_rld,
  input logic [DIV_W:0]   bit_cnt,
  input logic [DIV_W:0]   nxt_bit_rld
);
  AST_WR_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |-> (!smp_tick && !bit_tick)); // R8

  AST_BIT_WITH_SMP: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> smp_tick); // R9

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(cfg_err)); // R10

  AST_DIRECT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DIRECT && !cfg_wr) |-> smp_tick); // R5

  AST_PRESC_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PRESC && !cfg_wr) |-> (nxt_pre_rld >= PRE_W'(PRESC_BMIN))); // R4

  AST_DIRECT_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DIRECT && !cfg_wr) |-> (nxt_bit_rld >= (DIV_W+1)'(DIRECT_AMIN + 1))); // R6

  AST_X16_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_mode_en) |=> !cfg_err); // R7

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |-> (pre_cnt <= nxt_pre_rld)); // R2

  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |-> (bit_cnt <= nxt_bit_rld)); // R3
endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode_en(cfg_mode_en),
  .smp_tick(smp_tick), .bit_tick(bit_tick), .cfg_err(cfg_err),
  .mode_q(mode_q), .pre_cnt(pre_cnt), .nxt_pre_rld(nxt_pre_rld),
  .bit_cnt(bit_cnt), .nxt_bit_rld(nxt_bit_rld)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] a_in = '0;
  logic [3:0]  b_in = '0;
  logic        mode_en = 1'b0;
  logic        div_one = 1'b0;
  logic        bit_tick, smp_tick, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_t, m_g, m_p, m_mode;
  bit m_err;

  always #4 clk = ~clk;

  baud_tick_gen dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
    .cfg_base_div(a_in), .cfg_pre_div(b_in),
    .cfg_mode_en(mode_en), .cfg_div_one(div_one),
    .bit_tick(bit_tick), .smp_tick(smp_tick), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_t = 0; m_g = 16; m_p = 2; m_err = 1'b0; m_mode = 0;
    end else if (cfg_wr) begin
      m_t = 0;
      if (!mode_en) begin
        m_mode = 0; m_g = 16; m_p = int'(a_in) + 2; m_err = 1'b0;
      end else if (!div_one) begin
        m_mode = 1; m_err = (b_in < 8);
        m_g = (b_in < 8) ? 9 : int'(b_in) + 1;
        m_p = int'(a_in) + 2;
      end else begin
        m_mode = 2; m_g = 1; m_err = (a_in < 3);
        m_p = (a_in < 3) ? 5 : int'(a_in) + 2;
      end
    end else begin
      m_t = m_t + 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit es, eb;
      string tag;
      es = !cfg_wr && (((m_t + 1) % m_g) == 0);
      eb = !cfg_wr && (((m_t + 1) % (m_g * m_p)) == 0);
      if (cfg_wr)          tag = "R8";
      else if (m_mode == 0) tag = "R2";
      else if (m_mode == 1) tag = "R3";
      else                  tag = "R5";
      check(smp_tick == es, {tag, " smp_tick"}, smp_tick, es);
      check(bit_tick == eb, {tag, " bit_tick"}, bit_tick, eb);
      check(cfg_err == m_err, "R10 cfg_err", cfg_err, m_err);
      if (bit_tick) check(smp_tick, "R9 bit without smp", smp_tick, 1);
    end
  end

  task automatic write_cfg(input int a, input int b, input bit en, input bit one);
    @(posedge clk); #2;
    a_in = 16'(a); b_in = 4'(b); mode_en = en; div_one = one; cfg_wr = 1'b1;
    @(posedge clk); #2;
    cfg_wr = 1'b0;
  endtask

  task automatic first_ticks(input string tag, input int g, input int per);
    int n = 0;
    int first_s = 0;
    do begin
      @(negedge clk); n++;
      if (smp_tick && first_s == 0) first_s = n;
    end while (!bit_tick);
    check(first_s == g, {tag, " first smp"}, first_s, g);
    check(n == per, {tag, " first bit"}, n, per);
  endtask

  task automatic measure(input string tag, input int g, input int per);
    int n = 0;
    int s = 0;
    do @(negedge clk); while (!bit_tick);
    do begin
      @(negedge clk); n++;
      if (smp_tick && s == 0) s = n;
    end while (!bit_tick);
    check(n == per, {tag, " bit period"}, n, per);
    check(s == g, {tag, " smp period"}, s, g);
  endtask

  initial begin
    @(posedge clk); #2;
    @(negedge clk);
    check(!smp_tick && !bit_tick, "R1 no tick in reset", {smp_tick, bit_tick}, 0);
    check(!cfg_err, "R1 err in reset", cfg_err, 0);
    @(posedge clk); #2;
    rst = 1'b0;
    first_ticks("R1", 16, 32);
    measure("R1", 16, 32);

    write_cfg(3, 0, 0, 0);
    first_ticks("R8", 16, 80);
    measure("R2", 16, 80);

    write_cfg(2, 11, 1, 0);
    check(!cfg_err, "R3 err", cfg_err, 0);
    first_ticks("R8", 12, 48);
    measure("R3", 12, 48);

    write_cfg(1, 8, 1, 0);
    check(!cfg_err, "R4 B=8 legal", cfg_err, 0);
    measure("R4", 9, 27);

    write_cfg(1, 7, 1, 0);
    check(cfg_err, "R4 B=7 err", cfg_err, 1);
    measure("R4", 9, 27);

    write_cfg(10, 5, 1, 1);
    check(!cfg_err, "R10 legal clears err", cfg_err, 0);
    measure("R5", 1, 12);
    write_cfg(10, 14, 1, 1);
    measure("R5 B ignored", 1, 12);

    write_cfg(3, 0, 1, 1);
    check(!cfg_err, "R6 A=3 legal", cfg_err, 0);
    measure("R6", 1, 5);
    write_cfg(2, 0, 1, 1);
    check(cfg_err, "R6 A=2 err", cfg_err, 1);
    measure("R6", 1, 5);
    write_cfg(0, 0, 1, 1);
    check(cfg_err, "R6 A=0 err", cfg_err, 1);
    measure("R6", 1, 5);

    write_cfg(0, 3, 0, 1);
    check(!cfg_err, "R7 err", cfg_err, 0);
    measure("R7", 16, 32);

    write_cfg(10, 0, 1, 1);
    @(posedge clk); #2;
    a_in = 16'd1; b_in = 4'd2; mode_en = 1'b0; div_one = 1'b0;
    measure("R11", 1, 12);
    check(!cfg_err, "R11 err held", cfg_err, 0);

    write_cfg(1, 3, 1, 0);
    @(posedge clk); #2;
    a_in = 16'd20; b_in = 4'd12; mode_en = 1'b1; div_one = 1'b0;
    repeat (5) @(posedge clk);
    #2;
    check(cfg_err, "R11 err held high", cfg_err, 1);
    measure("R11", 9, 27);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule